// File: doc/BRIEF.md
# Pipelined Integer Square Root Unit

This block computes the floor of the square root of an unsigned integer, together with the remainder left over. It is fully pipelined. Every cycle it can take a new radicand, and each radicand moves through a chain of identical stages. Each stage settles exactly one bit of the root, starting with the most significant bit.

A stage pulls in the next two radicand bits below the remainder so far. It then tries to subtract a trial value: the partial root with binary `01` appended. If the trial value fits, the stage keeps the difference and records a root bit of one. If it does not fit, the stage keeps the shifted remainder unchanged and records a zero. The stage never adds anything back and never takes any other kind of step.

A valid flag travels beside each operand, so the caller can see which output cycles carry results. Results come out in the same order the radicands went in.

Top module: `isqrt_unit`

## Requirements
- R1: For a valid input `radicand` x of `RAD_W` bits (`RAD_W` even, at least 4), the matching `root` equals floor(sqrt(x)) and is `RAD_W/2` bits wide.
- R2: The matching `rem` equals x minus `root` squared, carried at `RAD_W/2 + 2` bits.
- R3: Every valid result satisfies `rem` <= 2 * `root`.
- R4: `out_valid` rises for a result exactly `RAD_W/2` clock cycles after the cycle in which `in_valid` was sampled high with that radicand.
- R5: A new radicand is accepted on every cycle with no stall. Back-to-back inputs each produce one result, in input order.
- R6: `rst` is synchronous and active high. It clears every in-flight valid flag. `out_valid` is low in the cycle after any cycle with `rst` high. Operands in flight at reset never appear at the output.
- R7: With `RAD_W` = 8, radicand 93 (binary 01011101) yields `root` 9 (binary 1001) and `rem` 12.
- R8: The boundary values work: radicand 0 gives 0/0, radicand 1 gives 1/0, and the all-ones radicand gives root 2^(RAD_W/2)-1 with `rem` 2^(RAD_W/2+1)-2. An exact square k*k gives root k with `rem` 0.
- R9: The same source builds for `RAD_W` of 8, 32 and 64 by changing only the parameter.
- R10: A cycle with `in_valid` low produces no result. The gap shows up as a cycle with `out_valid` low, exactly `RAD_W/2` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | High when `radicand` carries an operand this cycle |
| radicand | input | RAD_W | Unsigned value whose square root is wanted |
| out_valid | output | 1 | High when `root` and `rem` carry a result |
| root | output | RAD_W/2 | Floor of the square root |
| rem | output | RAD_W/2+2 | Radicand minus root squared |

## Verification
The bench builds three copies of the unit side by side, with `RAD_W` of 8, 32 and 64, and drives all three from one stream.

The 8-bit copy is small enough that a running counter walks every possible radicand, so each reachable remainder pattern and the worked 93 example are all covered. The 32-bit and 64-bit copies show that the parameter alone rescales the chain. The 64-bit copy also reaches the deepest pipeline and the widest remainder, including the all-ones input and the largest exact square.

On every copy, random gaps in `in_valid` and a reset issued while operands are in flight test the alignment of the valid flag.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    // Root width for a given radicand width.
    function automatic int root_width(input int rad_w);
        return rad_w / 2;
    endfunction

    // Remainder width: two bits above the root width.
    function automatic int rem_width(input int rad_w);
        return rad_w / 2 + 2;
    endfunction

    // Stage k still holds rad_w - 2k unconsumed radicand bits. The pieces of
    // all stages are packed back to back; this gives where piece k starts.
    function automatic int rest_offset(input int rad_w, input int k);
        return k * rad_w - k * (k - 1);
    endfunction

endpackage

// File: rtl/isqrt_stage.sv
module isqrt_stage #(
    parameter  int RAD_W  = 32,
    parameter  int IN_W   = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2,
    localparam int KEEP_W = (IN_W > 2) ? IN_W - 2 : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   rest_in,
    input  logic [REM_W-1:0]  rem_in,
    input  logic [ROOT_W-1:0] root_in,
    output logic              out_valid,
    output logic [KEEP_W-1:0] rest_out,
    output logic [REM_W-1:0]  rem_out,
    output logic [ROOT_W-1:0] root_out
);

    typedef struct packed {
        logic              valid;
        logic [KEEP_W-1:0] rest;
        logic [REM_W-1:0]  rem;
        logic [ROOT_W-1:0] root;
    } stage_t;

    stage_t            s_d, s_q;
    logic [1:0]        pair;
    logic [REM_W+1:0]  widened;
    logic [REM_W-1:0]  trial;
    logic [REM_W-1:0]  diff;
    logic              fits;
    logic [KEEP_W-1:0] rest_next;

    // The top two unconsumed radicand bits enter this stage.
    assign pair = rest_in[IN_W-1 -: 2];

    // Only the bits not yet consumed are carried on; the last stage has none.
    generate
        if (IN_W > 2) begin : g_carry
            assign rest_next = rest_in[IN_W-3:0];
        end else begin : g_drop
            assign rest_next = '0;
        end
    endgenerate

    always_comb begin
        widened     = {rem_in, pair};
        trial       = {root_in, 2'b01};
        fits        = (widened >= {2'b00, trial});
        diff        = widened[REM_W-1:0] - trial;
        s_d.valid   = in_valid;
        s_d.rest    = rest_next;
        s_d.rem     = fits ? diff : widened[REM_W-1:0];
        s_d.root    = {root_in[ROOT_W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
        if (rst) begin
            s_q.valid <= 1'b0;
        end
    end

    assign out_valid = s_q.valid;
    assign rest_out  = s_q.rest;
    assign rem_out   = s_q.rem;
    assign root_out  = s_q.root;

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
    import isqrt_pkg::*;
#(
    parameter  int RAD_W  = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = RAD_W / 2 + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RAD_W-1:0]  radicand,
    output logic              out_valid,
    output logic [ROOT_W-1:0] root,
    output logic [REM_W-1:0]  rem
);

    localparam int STAGES = root_width(RAD_W);
    localparam int REST_W = rest_offset(RAD_W, STAGES);

    logic [REST_W-1:0] rest_all;
    logic              vld_c  [0:STAGES];
    logic [REM_W-1:0]  rem_c  [0:STAGES];
    logic [ROOT_W-1:0] root_c [0:STAGES];
    logic              unused_tail;

    assign rest_all[rest_offset(RAD_W, 0) +: RAD_W] = radicand;
    assign vld_c[0]  = in_valid;
    assign rem_c[0]  = '0;
    assign root_c[0] = '0;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int IN_W  = RAD_W - 2 * k;
            localparam int KW    = (IN_W > 2) ? IN_W - 2 : 1;
            localparam int OFF   = rest_offset(RAD_W, k);
            localparam int OFF_N = rest_offset(RAD_W, k + 1);

            logic [KW-1:0] rest_o;

            isqrt_stage #(
                .RAD_W (RAD_W),
                .IN_W  (IN_W)
            ) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (vld_c[k]),
                .rest_in   (rest_all[OFF +: IN_W]),
                .rem_in    (rem_c[k]),
                .root_in   (root_c[k]),
                .out_valid (vld_c[k+1]),
                .rest_out  (rest_o),
                .rem_out   (rem_c[k+1]),
                .root_out  (root_c[k+1])
            );

            if (k < STAGES - 1) begin : g_link
                assign rest_all[OFF_N +: KW] = rest_o;
            end else begin : g_end
                assign unused_tail = rest_o[0];
            end
        end
    endgenerate

    assign out_valid = vld_c[STAGES];
    assign root      = root_c[STAGES];
    assign rem       = rem_c[STAGES];

endmodule

// File: rtl/isqrt_unit_chk.sv
module isqrt_unit_chk #(
    parameter  int RAD_W  = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = RAD_W / 2 + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [RAD_W-1:0]  radicand,
    input logic              out_valid,
    input logic [ROOT_W-1:0] root,
    input logic [REM_W-1:0]  rem
);

    logic [ROOT_W-1:0] vhist;
    logic [RAD_W-1:0]  rhist [0:ROOT_W-1];
    logic [RAD_W+1:0]  root_x, recon;
    logic [REM_W:0]    twice_root;

    always_ff @(posedge clk) begin
        if (rst) begin
            vhist <= '0;
        end else begin
            vhist <= {vhist[ROOT_W-2:0], in_valid};
        end
        rhist[0] <= radicand;
        for (int i = 1; i < ROOT_W; i++) begin
            rhist[i] <= rhist[i-1];
        end
    end

    always_comb begin
        root_x     = {{(RAD_W+2-ROOT_W){1'b0}}, root};
        recon      = root_x * root_x + {{(RAD_W+2-REM_W){1'b0}}, rem};
        twice_root = {1'b0, root, 1'b0};
    end

    AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid == vhist[ROOT_W-1]);                                      // R4
    AST_SQUARE_SUM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> recon == {2'b00, rhist[ROOT_W-1]});                   // R2
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> {1'b0, rem} <= twice_root);                           // R3
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid);                                                // R6

endmodule

bind isqrt_unit isqrt_unit_chk #(.RAD_W(RAD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .radicand  (radicand),
    .out_valid (out_valid),
    .root      (root),
    .rem       (rem)
);

// File: tb/isqrt_unit_test.sv
module isqrt_unit_test;

    typedef struct {
        logic [63:0] rad;
        int          t;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [7:0]  x8  = '0;
    logic [31:0] x32 = '0;
    logic [63:0] x64 = '0;

    logic        o8, o32, o64;
    logic [3:0]  r8;
    logic [5:0]  m8;
    logic [15:0] r32;
    logic [17:0] m32;
    logic [31:0] r64;
    logic [33:0] m64;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    item_t q8[$], q32[$], q64[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isqrt_unit #(.RAD_W(8)) uut_w8 (
        .clk(clk), .rst(rst), .in_valid(vld), .radicand(x8),
        .out_valid(o8), .root(r8), .rem(m8));
    isqrt_unit #(.RAD_W(32)) uut (
        .clk(clk), .rst(rst), .in_valid(vld), .radicand(x32),
        .out_valid(o32), .root(r32), .rem(m32));
    isqrt_unit #(.RAD_W(64)) uut_w64 (
        .clk(clk), .rst(rst), .in_valid(vld), .radicand(x64),
        .out_valid(o64), .root(r64), .rem(m64));

    task automatic report(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    // Independent model: greedy bit search on the square, 128-bit products.
    function automatic logic [63:0] ref_root(input logic [63:0] x, input int half);
        logic [63:0]  r = '0;
        logic [127:0] t;
        for (int b = half - 1; b >= 0; b--) begin
            t = 128'(r | (64'd1 << b));
            if (t * t <= 128'(x)) r = r | (64'd1 << b);
        end
        return r;
    endfunction

    task automatic judge(input string lane, input int half, input item_t it,
                         input logic [63:0] rt, input logic [63:0] rm);
        logic [63:0]  er;
        logic [127:0] erm;
        er  = ref_root(it.rad, half);
        erm = 128'(it.rad) - 128'(er) * 128'(er);
        report(rt == er, "R1", $sformatf("%s x=%0d root act=%0d exp=%0d", lane, it.rad, rt, er));
        report(128'(rm) == erm, "R2", $sformatf("%s x=%0d rem act=%0d exp=%0d", lane, it.rad, rm, erm));
        report(128'(rm) <= 2 * 128'(rt), "R3", $sformatf("%s x=%0d rem act=%0d bound=%0d", lane, it.rad, rm, 2 * rt));
        report(cyc - it.t == half, "R4", $sformatf("%s x=%0d latency act=%0d exp=%0d", lane, it.rad, cyc - it.t, half));
        if (half == 4 && it.rad == 64'd93)
            report(rt == 64'd9 && rm == 64'd12, "R7",
                   $sformatf("w8 x=93 act=%0d/%0d exp=9/12", rt, rm));
    endtask

    // Monitor: sample a quarter period after the rising edge.
    always begin
        item_t it;
        @(posedge clk);
        #5;
        if (!rst) begin
            if (o8) begin
                if (q8.size() == 0) report(1'b0, "R10", "w8 out_valid act=1 exp=0");
                else begin it = q8.pop_front(); judge("w8", 4, it, 64'(r8), 64'(m8)); end
            end
            if (o32) begin
                if (q32.size() == 0) report(1'b0, "R10", "w32 out_valid act=1 exp=0");
                else begin it = q32.pop_front(); judge("w32", 16, it, 64'(r32), 64'(m32)); end
            end
            if (o64) begin
                if (q64.size() == 0) report(1'b0, "R10", "w64 out_valid act=1 exp=0");
                else begin it = q64.pop_front(); judge("w64", 32, it, 64'(r64), 64'(m64)); end
            end
        end
    end

    task automatic drive(input bit v, input logic [7:0] a, input logic [31:0] b,
                         input logic [63:0] c);
        @(negedge clk);
        vld = v; x8 = a; x32 = b; x64 = c;
        if (v) begin
            q8.push_back('{64'(a), cyc});
            q32.push_back('{64'(b), cyc});
            q64.push_back('{c, cyc});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, '0);
    endtask

    task automatic quiet_check(input string req);
        @(negedge clk);
        report(!(o8 | o32 | o64), req,
               $sformatf("out_valid act=%0b%0b%0b exp=000", o8, o32, o64));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] k32;
        logic [31:0] k64;
        // R6: reset with valid data offered; nothing may come out.
        vld = 1'b1; x8 = 8'd50; x32 = 32'd77; x64 = 64'd99;
        for (int i = 0; i < 4; i++) quiet_check("R6");
        @(negedge clk); rst = 1'b0; vld = 1'b0;
        for (int i = 0; i < 34; i++) quiet_check("R6");

        // R7, R8: directed corner values, back to back.
        drive(1, 8'd93,  32'd0,          64'd0);
        drive(1, 8'd0,   32'd1,          64'd1);
        drive(1, 8'd1,   32'hFFFF_FFFF,  64'hFFFF_FFFF_FFFF_FFFF);
        drive(1, 8'd255, 32'hFFFE_0001,  64'hFFFF_FFFE_0000_0001);
        drive(1, 8'd225, 32'h4000_0000,  64'h4000_0000_0000_0000);
        drive(1, 8'd3,   32'd3,          64'hFFFF_FFFE_0000_0000);
        drive(1, 8'd4,   32'd15,         64'd2);
        idle(40);

        // R5, R9: back-to-back stream; w8 walks every value, exact squares mixed in.
        for (int i = 0; i < 3000; i++) begin
            k32 = $urandom;
            k64 = $urandom;
            if (i % 7 == 3)
                drive(1, 8'(i), 32'(k32[15:0]) * 32'(k32[15:0]), 64'(k64) * 64'(k64));
            else
                drive(1, 8'(i), $urandom, {$urandom, $urandom});
        end
        idle(40);

        // R10: random gaps in the input stream.
        for (int i = 0; i < 800; i++) begin
            if ($urandom % 2 == 0) drive(1, 8'($urandom), $urandom, {$urandom, $urandom});
            else drive(0, 8'($urandom), $urandom, {$urandom, $urandom});
        end
        idle(40);

        // R6: reset while operands are in flight; they must vanish.
        for (int i = 0; i < 10; i++) drive(1, 8'($urandom), $urandom, {$urandom, $urandom});
        @(negedge clk);
        rst = 1'b1; vld = 1'b0;
        q8.delete(); q32.delete(); q64.delete();
        quiet_check("R6");
        quiet_check("R6");
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 36; i++) quiet_check("R6");

        // Resume after reset.
        for (int i = 0; i < 20; i++) drive(1, 8'($urandom), $urandom, {$urandom, $urandom});
        idle(40);

        // R5: every accepted radicand produced a result.
        report(q8.size() == 0 && q32.size() == 0 && q64.size() == 0, "R5",
               $sformatf("pending act=%0d/%0d/%0d exp=0/0/0", q8.size(), q32.size(), q64.size()));
        finish_run();
    end

endmodule